// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

This block is the per-endpoint queue engine of a device controller. Software builds a ring of 16-byte transfer descriptors in memory, each naming a data buffer, its length and the address of the next descriptor, and hands a descriptor to the hardware by setting its ownership bit. Once started, the engine walks the ring on its own. For each descriptor it fetches the four words, checks them, asks the endpoint FIFO to move the buffer, writes the actual length back with ownership returned to software, and follows the next pointer.

The engine waits at the first descriptor that software still owns. It also waits at one with a bad checksum, and at a transmit descriptor of zero length, which it reports as a length error so that software can send the empty packet itself. Software then repairs or fills that descriptor and issues a resume, which makes the engine fetch the current descriptor again. A stop command lets the descriptor in flight finish, then clears the active flag. Software may poll that flag.

The memory port is a simple word-wide request/acknowledge interface. The FIFO side is a request/done handshake that reports how many bytes were moved.

Top module: `dring_qengine`

## Requirements
- R1: After reset, `active` is 0, `cur_ptr` is 0, and `mem_req`, `ep_req` and all three event outputs are 0.
- R2: While inactive, `cmd_start` loads `cur_ptr` from the start-address register (written through `sar_we`/`sar_wdata`) and sets `active`. A `cmd_start` while `active` is 1 leaves `cur_ptr` unchanged.
- R3: A descriptor is fetched as four word reads at `cur_ptr`, `cur_ptr`+4, +8 and +12, in that order. Its fields are:
  - word 0 bits [7:0]: flags (bit 0 hardware-owned, bit 2 bypass, bit 7 interrupt on completion);
  - word 0 bits [15:8]: checksum;
  - word 0 bits [31:16]: length;
  - word 1: next-descriptor address;
  - word 2: buffer address;
  - word 3 bits [7:0]: extension flags, bit 5 requesting a zero-length packet.
- R4: A fetched descriptor whose bit 0 is 0 parks the engine. While parked, `active` stays 1, `cur_ptr` does not change, no memory access is made and no event is raised.
- R5: With `csum_en` at 1, a descriptor whose 16 bytes do not sum to 8'hFF modulo 256 gives a one-cycle `cs_err_evt`. The engine then parks with no transfer and no write. With `csum_en` at 0 the sum is not checked.
- R6: An owned, valid, non-bypass descriptor raises `ep_req` with `ep_addr` = buffer address, `ep_len` = length and `ep_dir` = `dir_tx`. The actual length is the smaller of `ep_count` and the length.
- R7: After a transfer, word 0 is written back at `cur_ptr` with bit 0 cleared, the other flags and the checksum byte unchanged, and bits [31:16] set to the actual length. `cur_ptr` then takes the next-descriptor address and the following descriptor is fetched.
- R8: A descriptor with bypass set moves no data (`ep_req` stays 0). It is written back with length 0 and ownership cleared, and the engine advances.
- R9: A transmit descriptor (`dir_tx` = 1) of length 0 without bypass gives a one-cycle `len_err_evt` and parks with no write. A receive descriptor of length 0 is transferred normally.
- R10: During a transmit transfer `ep_zlp` equals extension bit 5. During a receive transfer it is 0.
- R11: `done_evt` pulses for one cycle after each descriptor write-back whose flag bit 7 is 1, and not otherwise.
- R12: `cmd_stop` while parked clears `active` at once. Otherwise the engine completes the descriptor in progress (write-back and advance), or stops at the check point if the stop arrived during a fetch. It then clears `active` and fetches nothing more.
- R13: `cmd_resume` re-fetches the descriptor at `cur_ptr` only when the engine is parked. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_resume | input | 1 | Resume command pulse |
| sar_we | input | 1 | Write strobe of the start-address register |
| sar_wdata | input | AW | Start-address value |
| csum_en | input | 1 | Enables descriptor checksum checking |
| dir_tx | input | 1 | 1 = transmit queue, 0 = receive queue |
| active | output | 1 | Queue active status |
| cur_ptr | output | AW | Address of the current descriptor |
| mem_req | output | 1 | Memory access request, held until acknowledge |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address in bytes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| ep_req | output | 1 | Transfer request to the endpoint FIFO |
| ep_dir | output | 1 | Transfer direction, 1 = transmit |
| ep_zlp | output | 1 | Append a zero-length packet (transmit only) |
| ep_addr | output | AW | Buffer address |
| ep_len | output | 16 | Buffer length in bytes |
| ep_done | input | 1 | Transfer finished pulse |
| ep_count | input | 16 | Bytes moved, valid with `ep_done` |
| done_evt | output | 1 | Descriptor-completed event |
| cs_err_evt | output | 1 | Checksum-error event |
| len_err_evt | output | 1 | Transmit length-error event |

## Verification
The hardest case to reach from the ports is the recovery path. A zero-length transmit descriptor parks the engine with a length error. Software then rewrites that same descriptor in memory as a bypass with a fresh checksum and resumes, and the engine must re-fetch from the unchanged current pointer and advance without touching the FIFO. The bench builds this case by editing its memory model while the engine is parked and then pulsing resume. It checks the parked pointer, the single error pulse, the written-back length of zero and the absence of any transfer. A second hard case is a stop landing in the middle of a slow FIFO transfer. The bench lengthens the stub's response so that the stop falls inside the transfer, then checks that write-back and advance still happen and that the next owned descriptor stays untouched.

// File: rtl/qe_pkg.sv
package qe_pkg;

  localparam int DESC_WORDS = 4;
  localparam int WIDX_W     = $clog2(DESC_WORDS);
  localparam int LEN_W      = 16;

  localparam int FLG_OWN  = 0;
  localparam int FLG_SKIP = 2;
  localparam int FLG_IRQ  = 7;
  localparam int EXT_ZLP  = 5;

  localparam logic [7:0] CSUM_GOOD = 8'hFF;

  typedef enum logic [2:0] {
    QS_IDLE,
    QS_FETCH,
    QS_CHECK,
    QS_MOVE,
    QS_WB,
    QS_ADV,
    QS_PARK
  } qstate_t;

endpackage

// File: rtl/qe_csum.sv
module qe_csum #(
  parameter int NW = 4
) (
  input  logic [NW-1:0][31:0] words,
  output logic [7:0]          sum,
  output logic                ok
);
  import qe_pkg::*;

  always_comb begin
    sum = 8'h00;
    for (int w = 0; w < NW; w++) begin
      for (int b = 0; b < 4; b++) begin
        sum = sum + words[w][b*8 +: 8];
      end
    end
    ok = (sum == CSUM_GOOD);
  end

endmodule

// File: rtl/qe_mover.sv
module qe_mover #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          dir_tx,
  input  logic          zlp_flag,
  input  logic [AW-1:0] buf_addr,
  input  logic [LW-1:0] len,
  output logic          ep_req,
  output logic          ep_dir,
  output logic          ep_zlp,
  output logic [AW-1:0] ep_addr,
  output logic [LW-1:0] ep_len,
  input  logic          ep_done,
  input  logic [LW-1:0] ep_count,
  output logic          fin,
  output logic [LW-1:0] act
);

  logic          busy_q, busy_n;
  logic          fin_q, fin_n;
  logic          dir_q, zlp_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] act_q, act_n;
  logic          act_en;

  always_comb begin
    busy_n = busy_q;
    fin_n  = 1'b0;
    act_n  = act_q;
    act_en = 1'b0;
    if (go) begin
      busy_n = 1'b1;
    end else if (busy_q && ep_done) begin
      busy_n = 1'b0;
      fin_n  = 1'b1;
      act_en = 1'b1;
      act_n  = (ep_count > len_q) ? len_q : ep_count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      act_q  <= '0;
      dir_q  <= 1'b0;
      zlp_q  <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
    end else begin
      busy_q <= busy_n;
      fin_q  <= fin_n;
      if (act_en) act_q <= act_n;
      if (go) begin
        dir_q  <= dir_tx;
        zlp_q  <= zlp_flag & dir_tx;
        addr_q <= buf_addr;
        len_q  <= len;
      end
    end
  end

  assign ep_req  = busy_q;
  assign ep_dir  = dir_q;
  assign ep_zlp  = busy_q & zlp_q;
  assign ep_addr = addr_q;
  assign ep_len  = len_q;
  assign fin     = fin_q;
  assign act     = act_q;

  AST_ACT_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (act <= len_q)); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q); // R6
  AST_RX_NO_ZLP: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_req && !ep_dir) |-> !ep_zlp); // R10

endmodule

// File: rtl/dring_qengine.sv
module dring_qengine #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          cmd_resume,
  input  logic          sar_we,
  input  logic [AW-1:0] sar_wdata,
  input  logic          csum_en,
  input  logic          dir_tx,
  output logic          active,
  output logic [AW-1:0] cur_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          ep_req,
  output logic          ep_dir,
  output logic          ep_zlp,
  output logic [AW-1:0] ep_addr,
  output logic [15:0]   ep_len,
  input  logic          ep_done,
  input  logic [15:0]   ep_count,
  output logic          done_evt,
  output logic          cs_err_evt,
  output logic          len_err_evt
);
  import qe_pkg::*;

  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(DESC_WORDS - 1);

  qstate_t                           state_q, state_n;
  logic [WIDX_W-1:0]                 widx_q, widx_n;
  logic [DESC_WORDS-1:0][31:0]       desc_q, desc_n;
  logic                              desc_en;
  logic [AW-1:0]                     cur_q, cur_n;
  logic [AW-1:0]                     sar_q;
  logic                              active_q, active_n;
  logic                              stop_q, stop_n;
  logic [LEN_W-1:0]                  wblen_q, wblen_n;

  logic                              own, skip, irq, zlp;
  logic [LEN_W-1:0]                  dlen;
  logic [7:0]                        csum;
  logic                              csum_ok;
  logic                              mv_go, mv_fin;
  logic [LEN_W-1:0]                  mv_act;

  assign own  = desc_q[0][FLG_OWN];
  assign skip = desc_q[0][FLG_SKIP];
  assign irq  = desc_q[0][FLG_IRQ];
  assign dlen = desc_q[0][31:16];
  assign zlp  = desc_q[3][EXT_ZLP];

  qe_csum #(.NW(DESC_WORDS)) i_csum (
    .words (desc_q),
    .sum   (csum),
    .ok    (csum_ok)
  );

  qe_mover #(.AW(AW), .LW(LEN_W)) i_mover (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (mv_go),
    .dir_tx   (dir_tx),
    .zlp_flag (zlp),
    .buf_addr (desc_q[2][AW-1:0]),
    .len      (dlen),
    .ep_req   (ep_req),
    .ep_dir   (ep_dir),
    .ep_zlp   (ep_zlp),
    .ep_addr  (ep_addr),
    .ep_len   (ep_len),
    .ep_done  (ep_done),
    .ep_count (ep_count),
    .fin      (mv_fin),
    .act      (mv_act)
  );

  always_comb begin
    state_n     = state_q;
    widx_n      = widx_q;
    desc_n      = desc_q;
    desc_en     = 1'b0;
    cur_n       = cur_q;
    active_n    = active_q;
    stop_n      = stop_q;
    wblen_n     = wblen_q;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = cur_q;
    mem_wdata   = '0;
    mv_go       = 1'b0;
    done_evt    = 1'b0;
    cs_err_evt  = 1'b0;
    len_err_evt = 1'b0;

    if (cmd_stop && active_q && state_q != QS_PARK) stop_n = 1'b1;

    unique case (state_q)
      QS_IDLE: begin
        if (cmd_start) begin
          cur_n    = sar_q;
          active_n = 1'b1;
          stop_n   = 1'b0;
          widx_n   = '0;
          state_n  = QS_FETCH;
        end
      end
      QS_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + AW'({widx_q, 2'b00});
        if (mem_ack) begin
          desc_en        = 1'b1;
          desc_n[widx_q] = mem_rdata;
          if (widx_q == LAST_WORD) state_n = QS_CHECK;
          else                     widx_n  = widx_q + 1'b1;
        end
      end
      QS_CHECK: begin
        if (stop_q) begin
          active_n = 1'b0;
          stop_n   = 1'b0;
          state_n  = QS_IDLE;
        end else if (!own) begin
          state_n = QS_PARK;
        end else if (csum_en && !csum_ok) begin
          cs_err_evt = 1'b1;
          state_n    = QS_PARK;
        end else if (skip) begin
          wblen_n = '0;
          state_n = QS_WB;
        end else if (dir_tx && dlen == '0) begin
          len_err_evt = 1'b1;
          state_n     = QS_PARK;
        end else begin
          mv_go   = 1'b1;
          state_n = QS_MOVE;
        end
      end
      QS_MOVE: begin
        if (mv_fin) begin
          wblen_n = mv_act;
          state_n = QS_WB;
        end
      end
      QS_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q;
        mem_wdata = {wblen_q, desc_q[0][15:8], desc_q[0][7:1], 1'b0};
        if (mem_ack) state_n = QS_ADV;
      end
      QS_ADV: begin
        cur_n    = desc_q[1][AW-1:0];
        done_evt = irq;
        widx_n   = '0;
        if (stop_q) begin
          active_n = 1'b0;
          stop_n   = 1'b0;
          state_n  = QS_IDLE;
        end else begin
          state_n = QS_FETCH;
        end
      end
      QS_PARK: begin
        if (cmd_stop) begin
          active_n = 1'b0;
          stop_n   = 1'b0;
          state_n  = QS_IDLE;
        end else if (cmd_resume) begin
          widx_n  = '0;
          state_n = QS_FETCH;
        end
      end
      default: state_n = QS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= QS_IDLE;
      widx_q   <= '0;
      desc_q   <= '0;
      cur_q    <= '0;
      sar_q    <= '0;
      active_q <= 1'b0;
      stop_q   <= 1'b0;
      wblen_q  <= '0;
    end else begin
      state_q  <= state_n;
      widx_q   <= widx_n;
      cur_q    <= cur_n;
      active_q <= active_n;
      stop_q   <= stop_n;
      wblen_q  <= wblen_n;
      if (desc_en) desc_q <= desc_n;
      if (sar_we)  sar_q  <= sar_wdata;
    end
  end

  assign active  = active_q;
  assign cur_ptr = cur_q;

  AST_PARK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == QS_PARK) |-> (!mem_req && !ep_req)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (!mem_req && !ep_req)); // R12
  AST_WB_DROPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[FLG_OWN]); // R7
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_evt, cs_err_evt, len_err_evt})); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cmd_start && state_q != QS_ADV) |=> $stable(cur_ptr)); // R2
  AST_XFER_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ep_req |-> !mem_req); // R6

endmodule

// File: tb/test_dring_qengine.sv
`timescale 1ns/1ps
module test_dring_qengine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0, cmd_stop = 1'b0, cmd_resume = 1'b0;
  logic        sar_we = 1'b0;
  logic [31:0] sar_wdata = '0;
  logic        csum_en = 1'b1, dir_tx = 1'b1;
  logic        active;
  logic [31:0] cur_ptr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        ep_req, ep_dir, ep_zlp;
  logic [31:0] ep_addr;
  logic [15:0] ep_len;
  logic        ep_done = 1'b0;
  logic [15:0] ep_count = '0;
  logic        done_evt, cs_err_evt, len_err_evt;

  always #4 clk = ~clk;

  dring_qengine #(.AW(32)) i_dring_qengine (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_resume(cmd_resume), .sar_we(sar_we), .sar_wdata(sar_wdata),
    .csum_en(csum_en), .dir_tx(dir_tx), .active(active), .cur_ptr(cur_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .ep_req(ep_req), .ep_dir(ep_dir), .ep_zlp(ep_zlp), .ep_addr(ep_addr),
    .ep_len(ep_len), .ep_done(ep_done), .ep_count(ep_count),
    .done_evt(done_evt), .cs_err_evt(cs_err_evt), .len_err_evt(len_err_evt)
  );

  logic [31:0] mem [0:255];
  int n_chk = 0, n_fail = 0;
  int n_done, n_cs, n_le, n_xfer, n_zlp, n_rd, n_mem;
  logic [31:0] rd_log [0:7];
  int ep_delay = 2;
  logic [15:0] ep_resp = '0;
  int stub_cnt = 0;
  logic prev_req = 1'b0;

  // memory model: one acknowledge per two cycles
  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      n_mem++;
      if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
      else begin
        mem_rdata = mem[mem_addr[9:2]];
        rd_log[n_rd % 8] = mem_addr;
        n_rd++;
      end
    end
  end

  // endpoint FIFO stub and event monitor
  initial forever begin
    @(negedge clk);
    if (ep_req && !prev_req) n_xfer++;
    if (ep_req && ep_zlp) n_zlp++;
    prev_req = ep_req;
    if (ep_done) ep_done = 1'b0;
    else if (ep_req) begin
      if (stub_cnt >= ep_delay) begin
        ep_done = 1'b1; ep_count = ep_resp; stub_cnt = 0;
      end else stub_cnt++;
    end
    if (done_evt) n_done++;
    if (cs_err_evt) n_cs++;
    if (len_err_evt) n_le++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clr_counts();
    n_done = 0; n_cs = 0; n_le = 0; n_xfer = 0; n_zlp = 0; n_rd = 0; n_mem = 0;
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [7:0] flags,
                          input logic [15:0] len, input logic [7:0] ext,
                          input logic [31:0] nxt, input logic [31:0] bufa,
                          input bit good, output logic [7:0] chk);
    logic [7:0] s;
    logic [31:0] w [4];
    w[0] = {len, 8'h00, flags}; w[1] = nxt; w[2] = bufa; w[3] = {24'h0, ext};
    s = 8'h00;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) s = s + w[a][b*8 +: 8];
    chk = 8'hFF - s;
    if (!good) chk = chk + 8'h01;
    mem[base[9:2]]       = {len, chk, flags};
    mem[base[9:2] + 8'd1] = nxt;
    mem[base[9:2] + 8'd2] = bufa;
    mem[base[9:2] + 8'd3] = w[3];
  endtask

  task automatic do_start(input logic [31:0] a);
    sar_we = 1'b1; sar_wdata = a; tick(1); sar_we = 1'b0;
    cmd_start = 1'b1; tick(1); cmd_start = 1'b0;
  endtask

  task automatic do_stop();
    cmd_stop = 1'b1; tick(1); cmd_stop = 1'b0;
  endtask

  task automatic do_resume();
    cmd_resume = 1'b1; tick(1); cmd_resume = 1'b0;
  endtask

  typedef struct packed {
    logic        tx;
    logic        cs_en;
    logic [7:0]  flags;
    logic [15:0] len;
    logic [7:0]  ext;
    logic        good;
    logic [15:0] epcnt;
    logic        adv;
    logic [15:0] elen;
    logic        done;
    logic        cs;
    logic        le;
    logic        xfer;
    logic        zlp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 8'h81, 16'd100, 8'h00, 1'b1, 16'd100, 1'b1, 16'd100, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 R7 R11 tx
    '{1'b1, 1'b1, 8'h01, 16'd8,   8'h00, 1'b1, 16'd8,   1'b1, 16'd8,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R11 no irq flag
    '{1'b0, 1'b1, 8'h81, 16'd64,  8'h00, 1'b1, 16'd20,  1'b1, 16'd20,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 short rx
    '{1'b0, 1'b1, 8'h81, 16'd10,  8'h00, 1'b1, 16'd50,  1'b1, 16'd10,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 clipped
    '{1'b1, 1'b1, 8'h81, 16'd12,  8'h00, 1'b0, 16'd12,  1'b0, 16'd0,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 bad sum
    '{1'b1, 1'b0, 8'h81, 16'd12,  8'h00, 1'b0, 16'd12,  1'b1, 16'd12,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 check off
    '{1'b1, 1'b1, 8'h85, 16'd30,  8'h00, 1'b1, 16'd0,   1'b1, 16'd0,   1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 bypass
    '{1'b1, 1'b1, 8'h81, 16'd0,   8'h00, 1'b1, 16'd0,   1'b0, 16'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R9 tx zero
    '{1'b1, 1'b1, 8'h80, 16'd40,  8'h00, 1'b1, 16'd40,  1'b0, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 not owned
    '{1'b0, 1'b1, 8'h81, 16'd0,   8'h00, 1'b1, 16'd0,   1'b1, 16'd0,   1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R9 rx zero
    '{1'b1, 1'b1, 8'h81, 16'd5,   8'h20, 1'b1, 16'd5,   1'b1, 16'd5,   1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R10 tx zlp
    '{1'b0, 1'b1, 8'h81, 16'd6,   8'h20, 1'b1, 16'd6,   1'b1, 16'd6,   1'b1, 1'b0, 1'b0, 1'b1, 1'b0}  // R10 rx no zlp
  };

  initial begin
    logic [7:0] chk, chk_b;
    logic [31:0] base, w0;
    for (int k = 0; k < 256; k++) mem[k] = '0;
    clr_counts();
    tick(3);
    // R1 reset state
    check("R1 active", {31'h0, active}, 32'h0);
    check("R1 cur_ptr", cur_ptr, 32'h0);
    check("R1 bus idle", {29'h0, mem_req, ep_req, done_evt | cs_err_evt | len_err_evt}, 32'h0);
    rst_n = 1'b1;
    tick(2);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      base = 32'h100 + 32'(i) * 32;
      put_desc(base, v.flags, v.len, v.ext, base + 32'd16, 32'h8000 + 32'(i), v.good, chk);
      w0 = {v.len, chk, v.flags};
      mem[base[9:2] + 8'd4] = 32'h0;
      dir_tx = v.tx; csum_en = v.cs_en; ep_resp = v.epcnt;
      clr_counts();
      do_start(base);
      tick(80);
      check($sformatf("R2/R4 vec%0d active", i), {31'h0, active}, 32'h1);
      check($sformatf("R7 vec%0d cur_ptr", i), cur_ptr, v.adv ? base + 32'd16 : base);
      check($sformatf("R7/R8 vec%0d word0", i), mem[base[9:2]],
            v.adv ? {v.elen, chk, v.flags & 8'hFE} : w0);
      check($sformatf("R11 vec%0d done", i), n_done, {31'h0, v.done});
      check($sformatf("R5 vec%0d cs_err", i), n_cs, {31'h0, v.cs});
      check($sformatf("R9 vec%0d len_err", i), n_le, {31'h0, v.le});
      check($sformatf("R6/R8 vec%0d xfer", i), n_xfer, {31'h0, v.xfer});
      check($sformatf("R10 vec%0d zlp", i), {31'h0, n_zlp != 0}, {31'h0, v.zlp});
      if (i == 0) begin
        check("R3 fetch word0", rd_log[0], base);
        check("R3 fetch word1", rd_log[1], base + 32'd4);
        check("R3 fetch word2", rd_log[2], base + 32'd8);
        check("R3 fetch word3", rd_log[3], base + 32'd12);
      end
      do_stop();
      tick(2);
      check($sformatf("R12 vec%0d stop from park", i), {31'h0, active}, 32'h0);
    end

    // R2: start while active is ignored
    dir_tx = 1'b1; csum_en = 1'b1;
    mem[8'hC0] = 32'h0;
    do_start(32'h300);
    tick(30);
    do_start(32'h340);
    tick(30);
    check("R2 start ignored", cur_ptr, 32'h300);
    do_stop(); tick(2);

    // R13: resume while idle has no effect
    clr_counts();
    do_resume();
    tick(20);
    check("R13 resume idle active", {31'h0, active}, 32'h0);
    check("R13 resume idle no access", n_mem, 0);

    // R9/R4/R13: length-error park, repair as bypass, resume
    clr_counts();
    put_desc(32'h380, 8'h81, 16'd0, 8'h00, 32'h390, 32'h9000, 1'b1, chk);
    mem[8'hE4] = 32'h0;
    do_start(32'h380);
    tick(60);
    check("R9 repair len_err", n_le, 1);
    check("R4 repair parked ptr", cur_ptr, 32'h380);
    put_desc(32'h380, 8'h85, 16'd0, 8'h00, 32'h390, 32'h9000, 1'b1, chk);
    do_resume();
    tick(60);
    check("R13 resume advances", cur_ptr, 32'h390);
    check("R8 repaired word0", mem[8'hE0], {16'd0, chk, 8'h84});
    check("R8 repaired no xfer", n_xfer, 0);
    check("R11 repaired done", n_done, 1);
    do_stop(); tick(2);

    // R7: two-entry ring wraps and parks on the first entry
    clr_counts();
    put_desc(32'h3C0, 8'h81, 16'd4, 8'h00, 32'h3D0, 32'hA000, 1'b1, chk);
    put_desc(32'h3D0, 8'h81, 16'd6, 8'h00, 32'h3C0, 32'hB000, 1'b1, chk_b);
    ep_resp = 16'd200;
    do_start(32'h3C0);
    tick(150);
    check("R7 ring parked at head", cur_ptr, 32'h3C0);
    check("R7 ring first wb", mem[8'hF0], {16'd4, chk, 8'h80});
    check("R7 ring second wb", mem[8'hF4], {16'd6, chk_b, 8'h80});
    check("R11 ring done count", n_done, 2);
    do_stop(); tick(2);

    // R12: stop during a slow transfer completes that descriptor only
    clr_counts();
    ep_delay = 20; ep_resp = 16'd9;
    put_desc(32'h3E0, 8'h81, 16'd9, 8'h00, 32'h3F0, 32'hC000, 1'b1, chk);
    put_desc(32'h3F0, 8'h81, 16'd7, 8'h00, 32'h3E0, 32'hD000, 1'b1, chk_b);
    do_start(32'h3E0);
    tick(14);
    do_stop();
    tick(60);
    check("R12 stop mid active", {31'h0, active}, 32'h0);
    check("R12 stop mid ptr", cur_ptr, 32'h3F0);
    check("R12 stop mid wb", mem[8'hF8], {16'd9, chk, 8'h80});
    check("R12 next untouched", mem[8'hFC], {16'd7, chk_b, 8'h81});
    check("R12 one xfer", n_xfer, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule